// File: doc/BRIEF.md
# Banked Nibble-Register Calendar Clock

A calendar clock that keeps seconds, minutes, hours, day of week, day, month and year as BCD digits and is reached through a narrow bus slave: a 4-bit address, 4-bit write and read data, and single-cycle write and read strobes. Sixteen 4-bit locations are visible. Three of them (control, test, action) are present whatever bank is selected. The other thirteen are switched by a 2-bit bank field in the control register. One bank shows the time digits. One shows alarm digits, the 12/24-hour select and a leap-year counter. Two banks are plain 13-nibble scratch memories.

A single-cycle 1 Hz tick pulse advances the clock. Software clears the timer-enable bit before it reads or sets the time, so that the digits cannot roll over while it is accessing them. A tick that arrives during the hold is remembered and applied once counting resumes. Writes to the action register discard that remembered second or clear the alarm digits.

Top module: `nibble_rtc`

## Requirements
- R1: Addresses 0xD (control), 0xE (test) and 0xF (action) are reachable in every bank. Control reads back all four bits written. Bits [1:0] pick the bank: 00 time, 01 alarm/setup, 10 scratch A, 11 scratch B. Bit 3 enables the timer and bit 2 is the alarm enable, which is stored only. Control resets to 4'b1000.
- R2: In the time bank, addresses 0x0..0xC hold second units, second tens, minute units, minute tens, hour units, hour tens, weekday, day units, day tens, month units, month tens, year units and year tens. After reset they hold 00:00:00, weekday 0, day 01, month 01, year 00.
- R3: Each applied tick advances seconds. Carries run seconds to minutes to hours to day to month to year, all in BCD. Years wrap 99 to 00, and the weekday counts 0..6 and steps with each day carry.
- R4: Day wraps after 30 for months 4, 6, 9 and 11, and after 31 for the other months. In February it wraps after 29 when the leap counter (setup bank 0xB) is 0, and after 28 otherwise. Each year carry steps the leap counter modulo 4.
- R5: Setup bank 0xA bit 0 set selects 24-hour counting (23 wraps to 00 with a day carry). Clear selects 12-hour counting, with hours 1..12 and the PM flag in bit 1 of the hour-tens digit. 11 AM steps to 12 PM, 12 steps to 1, and 11 PM steps to 12 AM with a day carry. Reset value is 24-hour.
- R6: While control bit 3 is 0, ticks leave the digits unchanged. Once it returns to 1, exactly one held second is applied, however many ticks arrived during the hold.
- R7: Writes to time-bank digits and to the leap counter are visible on the next read.
- R8: Writing the action register with bit 1 set discards a held second.
- R9: Writing the action register with bit 0 set clears the alarm digits (setup bank 0x2..0x8) and leaves the time and the 12/24 select alone.
- R10: Each scratch bank stores 13 independent nibbles at 0x0..0xC. A write to one bank leaves the other bank and the time digits unchanged.
- R11: Writes to the test register have no effect on counting. The test and action registers read as 0.
- R12: Setup bank addresses 0x0, 0x1, 0x9 and 0xC read as 0, and read data is 0 while the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_1hz | input | 1 | One-cycle pulse per second |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 4 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 4 | Read data, combinational from bus_addr while bus_rd is high |

## Verification
The hardest state to reach from the ports is a carry that runs through the whole chain. It happens once a year at the turn of December and once per February per leap phase, so waiting for it with ticks is not practical. The bench instead writes digits that sit one second before each boundary, with the leap counter preset. Random rounds are biased so that half of them start at the last minute of the day on the last day of the month, in either hour mode. The hold path is reached by clearing timer enable and sending several ticks. The held second is then either released or discarded through the action register.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NIB_W  = 4;
  localparam int ADDR_W = 4;
  localparam int DIGITS = 13;

  typedef enum logic [1:0] {
    BANK_CLOCK = 2'b00,
    BANK_SETUP = 2'b01,
    BANK_RAM_A = 2'b10,
    BANK_RAM_B = 2'b11
  } bank_e;

  localparam logic [ADDR_W-1:0] A_CTRL   = 4'hD;
  localparam logic [ADDR_W-1:0] A_TEST   = 4'hE;
  localparam logic [ADDR_W-1:0] A_ACTION = 4'hF;
  localparam logic [ADDR_W-1:0] A_HSEL   = 4'hA;
  localparam logic [ADDR_W-1:0] A_LEAP   = 4'hB;
  localparam logic [ADDR_W-1:0] A_LASTLO = 4'hC;

  // digit positions in the time bank (ordering is decoded by software)
  localparam int D_SEC_U = 0;
  localparam int D_SEC_T = 1;
  localparam int D_MIN_U = 2;
  localparam int D_MIN_T = 3;
  localparam int D_HR_U  = 4;
  localparam int D_HR_T  = 5;
  localparam int D_WDAY  = 6;
  localparam int D_DAY_U = 7;
  localparam int D_DAY_T = 8;
  localparam int D_MON_U = 9;
  localparam int D_MON_T = 10;
  localparam int D_YR_U  = 11;
  localparam int D_YR_T  = 12;

  function automatic logic [7:0] bcd_val(input logic [3:0] t, input logic [3:0] u);
    return 8'(t) * 8'd10 + 8'(u);
  endfunction

  function automatic logic [3:0] tens_of(input logic [7:0] v);
    logic [7:0] q;
    q = v / 8'd10;
    return q[3:0];
  endfunction

  function automatic logic [3:0] units_of(input logic [7:0] v);
    logic [7:0] r;
    r = v % 8'd10;
    return r[3:0];
  endfunction

  function automatic logic [7:0] month_days(input logic [7:0] mo, input logic leap_now);
    case (mo)
      8'd2:                      return leap_now ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:   return 8'd30;
      default:                   return 8'd31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int ALARM_LO = 2,
  parameter int ALARM_HI = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr,
  input  logic [ADDR_W-1:0]                  addr,
  input  logic [NIB_W-1:0]                   wdata,
  output logic [NIB_W-1:0]                   ctrl,
  output logic                               hour24,
  output logic                               clr_frac,
  output logic [ALARM_HI-ALARM_LO:0][NIB_W-1:0] alarm
);
  localparam int ALARM_N = ALARM_HI - ALARM_LO + 1;

  logic [NIB_W-1:0]                ctrl_q, ctrl_d;
  logic                            h24_q, h24_d;
  logic [ALARM_N-1:0][NIB_W-1:0]   alm_q, alm_d;
  logic                            ctrl_we, act_we, in_setup;

  assign in_setup = (ctrl_q[1:0] == BANK_SETUP);
  assign ctrl_we  = wr && (addr == A_CTRL);
  assign act_we   = wr && (addr == A_ACTION);
  assign clr_frac = act_we && wdata[1];

  always_comb begin
    ctrl_d = ctrl_q;
    h24_d  = h24_q;
    alm_d  = alm_q;
    if (ctrl_we) ctrl_d = wdata;
    if (wr && in_setup && (addr == A_HSEL)) h24_d = wdata[0];
    for (int i = 0; i < ALARM_N; i++) begin
      if (wr && in_setup && (int'(addr) == ALARM_LO + i)) alm_d[i] = wdata;
    end
    if (act_we && wdata[0]) alm_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= 4'b1000;
      h24_q  <= 1'b1;
      alm_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      h24_q  <= h24_d;
      alm_q  <= alm_d;
    end
  end

  assign ctrl   = ctrl_q;
  assign hour24 = h24_q;
  assign alarm  = alm_q;

  assert_ctrl_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> (ctrl_q == $past(wdata)));

  assert_alarm_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (act_we && wdata[0]) |=> (alm_q == '0));

  assert_alarm_clear_keeps_hsel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (act_we && wdata[0]) |=> $stable(h24_q));
endmodule

// File: rtl/rtc_scratch.sv
module rtc_scratch
  import rtc_pkg::*;
#(
  parameter int WORDS  = 13,
  parameter int BLOCKS = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr,
  input  logic [$clog2(BLOCKS)-1:0]     blk,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [NIB_W-1:0]              wdata,
  output logic [NIB_W-1:0]              rdata
);
  logic [BLOCKS-1:0][WORDS-1:0][NIB_W-1:0] mem_q, mem_d;

  for (genvar b = 0; b < BLOCKS; b++) begin : g_blk
    always_comb begin
      mem_d[b] = mem_q[b];
      for (int w = 0; w < WORDS; w++) begin
        if (wr && (int'(blk) == b) && (int'(addr) == w)) mem_d[b][w] = wdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem_q[b] <= '0;
      else        mem_q[b] <= mem_d[b];
    end

    assert_bank_isolation_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && (int'(blk) != b)) |=> $stable(mem_q[b]));
  end

  always_comb begin
    rdata = '0;
    for (int b = 0; b < BLOCKS; b++) begin
      for (int w = 0; w < WORDS; w++) begin
        if ((int'(blk) == b) && (int'(addr) == w)) rdata = mem_q[b][w];
      end
    end
  end
endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
  import rtc_pkg::*;
#(
  parameter int YEAR_SPAN  = 100,
  parameter int LEAP_CYCLE = 4,
  parameter int LEAP_W     = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          tick,
  input  logic                          timer_en,
  input  logic                          hour24,
  input  logic                          clr_frac,
  input  logic                          dig_we,
  input  logic [ADDR_W-1:0]             dig_addr,
  input  logic [NIB_W-1:0]              dig_data,
  input  logic                          leap_we,
  input  logic [LEAP_W-1:0]             leap_data,
  output logic [DIGITS-1:0][NIB_W-1:0]  digits,
  output logic [LEAP_W-1:0]             leap
);
  logic [DIGITS-1:0][NIB_W-1:0] dig_q, dig_d;
  logic [LEAP_W-1:0]            leap_q, leap_d;
  logic                         pend_q, pend_d;
  logic                         want, adv;

  logic [7:0] s, mi, h24v, h12v, d, mo, y, wd;
  logic [7:0] s_n, mi_n, h_n, d_n, mo_n, y_n, wd_n, dmax;
  logic       c_min, c_hr, c_day, c_mon, c_yr, pm, pm_n;
  logic [3:0] hr_t_n;

  // a held second survives until the timer runs again; a digit write defers it
  assign want   = tick || pend_q;
  assign adv    = timer_en && want && !dig_we && !clr_frac;
  assign pend_d = clr_frac ? 1'b0 : (want && !adv);

  always_comb begin
    s    = bcd_val(dig_q[D_SEC_T], dig_q[D_SEC_U]);
    mi   = bcd_val(dig_q[D_MIN_T], dig_q[D_MIN_U]);
    h24v = bcd_val({2'b00, dig_q[D_HR_T][1:0]}, dig_q[D_HR_U]);
    h12v = bcd_val({3'b000, dig_q[D_HR_T][0]}, dig_q[D_HR_U]);
    pm   = dig_q[D_HR_T][1];
    d    = bcd_val(dig_q[D_DAY_T], dig_q[D_DAY_U]);
    mo   = bcd_val(dig_q[D_MON_T], dig_q[D_MON_U]);
    y    = bcd_val(dig_q[D_YR_T], dig_q[D_YR_U]);
    wd   = 8'(dig_q[D_WDAY]);
    dmax = month_days(mo, leap_q == '0);

    c_min = (s >= 8'd59);
    s_n   = c_min ? 8'd0 : s + 8'd1;
    c_hr  = c_min && (mi >= 8'd59);
    mi_n  = (mi >= 8'd59) ? 8'd0 : mi + 8'd1;

    pm_n  = pm;
    if (hour24) begin
      c_day  = c_hr && (h24v >= 8'd23);
      h_n    = (h24v >= 8'd23) ? 8'd0 : h24v + 8'd1;
      hr_t_n = tens_of(h_n);
    end else begin
      if (h12v == 8'd11) begin
        h_n   = 8'd12;
        pm_n  = !pm;
        c_day = c_hr && pm;
      end else if (h12v >= 8'd12 || h12v == 8'd0) begin
        h_n   = 8'd1;
        c_day = 1'b0;
      end else begin
        h_n   = h12v + 8'd1;
        c_day = 1'b0;
      end
      hr_t_n = {2'b00, pm_n, (h_n >= 8'd10)};
    end

    c_mon = c_day && (d >= dmax);
    d_n   = (d >= dmax) ? 8'd1 : d + 8'd1;
    wd_n  = (wd >= 8'd6) ? 8'd0 : wd + 8'd1;
    c_yr  = c_mon && (mo >= 8'd12);
    mo_n  = (mo >= 8'd12) ? 8'd1 : mo + 8'd1;
    y_n   = (y >= 8'(YEAR_SPAN - 1)) ? 8'd0 : y + 8'd1;
  end

  always_comb begin
    dig_d  = dig_q;
    leap_d = leap_q;
    if (adv) begin
      dig_d[D_SEC_U] = units_of(s_n);
      dig_d[D_SEC_T] = tens_of(s_n);
      if (c_min) begin
        dig_d[D_MIN_U] = units_of(mi_n);
        dig_d[D_MIN_T] = tens_of(mi_n);
      end
      if (c_hr) begin
        dig_d[D_HR_U] = units_of(h_n);
        dig_d[D_HR_T] = hr_t_n;
      end
      if (c_day) begin
        dig_d[D_DAY_U] = units_of(d_n);
        dig_d[D_DAY_T] = tens_of(d_n);
        dig_d[D_WDAY]  = wd_n[3:0];
      end
      if (c_mon) begin
        dig_d[D_MON_U] = units_of(mo_n);
        dig_d[D_MON_T] = tens_of(mo_n);
      end
      if (c_yr) begin
        dig_d[D_YR_U] = units_of(y_n);
        dig_d[D_YR_T] = tens_of(y_n);
        leap_d = (leap_q == LEAP_W'(LEAP_CYCLE - 1)) ? '0 : leap_q + 1'b1;
      end
    end
    for (int w = 0; w < DIGITS; w++) begin
      if (dig_we && (int'(dig_addr) == w)) dig_d[w] = dig_data;
    end
    if (leap_we) leap_d = leap_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dig_q          <= '0;
      dig_q[D_DAY_U] <= 4'd1;
      dig_q[D_MON_U] <= 4'd1;
      leap_q         <= '0;
      pend_q         <= 1'b0;
    end else begin
      dig_q  <= dig_d;
      leap_q <= leap_d;
      pend_q <= pend_d;
    end
  end

  assign digits = dig_q;
  assign leap   = leap_q;

  assert_hold_freezes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!timer_en && !dig_we) |=> $stable(dig_q));

  assert_held_second_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!timer_en && tick && !clr_frac) |=> pend_q);

  assert_discard_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_frac |=> (!pend_q && $stable(dig_q[D_SEC_U])));

  assert_sec_units_bcd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (dig_q[D_SEC_U] <= 4'd9));

  assert_wday_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && c_day) |=> (dig_q[D_WDAY] <= 4'd6));
endmodule

// File: rtl/nibble_rtc.sv
module nibble_rtc
  import rtc_pkg::*;
#(
  parameter int RAM_WORDS  = 13,
  parameter int YEAR_SPAN  = 100,
  parameter int LEAP_CYCLE = 4,
  parameter int ALARM_LO   = 2,
  parameter int ALARM_HI   = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_1hz,
  input  logic [3:0]  bus_addr,
  input  logic [3:0]  bus_wdata,
  input  logic        bus_wr,
  input  logic        bus_rd,
  output logic [3:0]  bus_rdata
);
  localparam int LEAP_W  = (LEAP_CYCLE > 1) ? $clog2(LEAP_CYCLE) : 1;
  localparam int ALARM_N = ALARM_HI - ALARM_LO + 1;

  logic [1:0]                      rsync_q;
  logic                            rst_i_n;
  logic [NIB_W-1:0]                ctrl;
  bank_e                           bank;
  logic                            hour24, clr_frac;
  logic [ALARM_N-1:0][NIB_W-1:0]   alarm;
  logic [DIGITS-1:0][NIB_W-1:0]    digits;
  logic [LEAP_W-1:0]               leap;
  logic [NIB_W-1:0]                ram_rdata, rd_val;
  logic                            lo_hit, wr_clock, wr_leap, wr_ram;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  assign bank     = bank_e'(ctrl[1:0]);
  assign lo_hit   = (bus_addr <= A_LASTLO);
  assign wr_clock = bus_wr && lo_hit && (bank == BANK_CLOCK);
  assign wr_leap  = bus_wr && (bank == BANK_SETUP) && (bus_addr == A_LEAP);
  assign wr_ram   = bus_wr && lo_hit && ctrl[1];

  rtc_ctrl #(.ALARM_LO(ALARM_LO), .ALARM_HI(ALARM_HI)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .wr       (bus_wr),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .ctrl     (ctrl),
    .hour24   (hour24),
    .clr_frac (clr_frac),
    .alarm    (alarm)
  );

  rtc_timekeeper #(.YEAR_SPAN(YEAR_SPAN), .LEAP_CYCLE(LEAP_CYCLE), .LEAP_W(LEAP_W)) u_time (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .tick      (tick_1hz),
    .timer_en  (ctrl[3]),
    .hour24    (hour24),
    .clr_frac  (clr_frac),
    .dig_we    (wr_clock),
    .dig_addr  (bus_addr),
    .dig_data  (bus_wdata),
    .leap_we   (wr_leap),
    .leap_data (bus_wdata[LEAP_W-1:0]),
    .digits    (digits),
    .leap      (leap)
  );

  rtc_scratch #(.WORDS(RAM_WORDS), .BLOCKS(2)) u_ram (
    .clk   (clk),
    .rst_n (rst_i_n),
    .wr    (wr_ram),
    .blk   (ctrl[0]),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .rdata (ram_rdata)
  );

  always_comb begin
    rd_val = '0;
    if (bus_addr == A_CTRL) begin
      rd_val = ctrl;
    end else if (lo_hit) begin
      case (bank)
        BANK_CLOCK: begin
          for (int w = 0; w < DIGITS; w++) begin
            if (int'(bus_addr) == w) rd_val = digits[w];
          end
        end
        BANK_SETUP: begin
          if (bus_addr == A_HSEL)      rd_val = {3'b000, hour24};
          else if (bus_addr == A_LEAP) rd_val = NIB_W'(leap);
          else begin
            for (int i = 0; i < ALARM_N; i++) begin
              if (int'(bus_addr) == ALARM_LO + i) rd_val = alarm[i];
            end
          end
        end
        default: rd_val = ram_rdata;
      endcase
    end
  end

  assign bus_rdata = bus_rd ? rd_val : '0;
endmodule

// File: tb/nibble_rtc_test.sv
module nibble_rtc_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_1hz = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [3:0] bus_wdata = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [3:0] bus_rdata;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference model of the calendar
  int ms, mm, mh, mpm, mdow, mday, mmon, myr, mleap, m24;

  nibble_rtc uut (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata)
  );

  always #5 clk = ~clk;

  initial begin
    #(200000 * 10);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: run did not complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(string req, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got=%0d exp=%0d", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [3:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output int v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    v = int'(bus_rdata);
    bus_rd = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk);
    tick_1hz = 1'b1;
    @(negedge clk);
    tick_1hz = 1'b0;
  endtask

  function automatic int mdim(int mo, int lp);
    if (mo == 2) return (lp == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic int exp_digit(int i);
    case (i)
      0: return ms % 10;
      1: return ms / 10;
      2: return mm % 10;
      3: return mm / 10;
      4: return mh % 10;
      5: return m24 ? mh / 10 : (mpm * 2 + mh / 10);
      6: return mdow;
      7: return mday % 10;
      8: return mday / 10;
      9: return mmon % 10;
      10: return mmon / 10;
      11: return myr % 10;
      default: return myr / 10;
    endcase
  endfunction

  task automatic m_tick();
    bit cd;
    cd = 0;
    ms++;
    if (ms == 60) begin
      ms = 0; mm++;
      if (mm == 60) begin
        mm = 0;
        if (m24) begin
          mh = (mh + 1) % 24;
          cd = (mh == 0);
        end else if (mh == 11) begin
          mh = 12;
          if (mpm == 1) begin mpm = 0; cd = 1; end
          else mpm = 1;
        end else if (mh == 12) mh = 1;
        else mh++;
      end
    end
    if (cd) begin
      mdow = (mdow + 1) % 7;
      mday++;
      if (mday > mdim(mmon, mleap)) begin
        mday = 1; mmon++;
        if (mmon == 13) begin
          mmon = 1;
          myr = (myr + 1) % 100;
          mleap = (mleap + 1) % 4;
        end
      end
    end
  endtask

  task automatic tick_both();
    pulse();
    m_tick();
  endtask

  // R7: digits written in the held time bank, setup values in the setup bank
  task automatic load_model();
    wr(4'hD, 4'h1);
    wr(4'hA, 4'(m24));
    wr(4'hB, 4'(mleap));
    wr(4'hD, 4'h0);
    for (int i = 0; i < 13; i++) wr(4'(i), 4'(exp_digit(i)));
    wr(4'hD, 4'h8);
  endtask

  task automatic cmp_all(string req);
    int v;
    for (int i = 0; i < 13; i++) begin
      rd(4'(i), v);
      chk($sformatf("%s digit %0d", req, i), v, exp_digit(i));
    end
    wr(4'hD, 4'h9);
    rd(4'hB, v); chk($sformatf("%s leap", req), v, mleap);
    rd(4'hA, v); chk($sformatf("%s hsel", req), v, m24);
    wr(4'hD, 4'h8);
  endtask

  initial begin
    int v, s0, n;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 R2: reset state
    rd(4'hD, v); chk("R1 ctrl reset", v, 8);
    ms = 0; mm = 0; mh = 0; mpm = 0; mdow = 0; mday = 1; mmon = 1; myr = 0; mleap = 0; m24 = 1;
    cmp_all("R2 reset");

    // R3: plain counting
    repeat (5) tick_both();
    cmp_all("R3 count");

    // R3 R4: full carry into a new year, leap counter wraps 3 -> 0
    ms = 59; mm = 59; mh = 23; mdow = 6; mday = 31; mmon = 12; myr = 99; mleap = 3; m24 = 1;
    load_model();
    tick_both();
    chk("R3 year wrap", exp_digit(12) * 10 + exp_digit(11), 0);
    cmp_all("R3 new year");

    // R4: February with leap counter 0 and 1, and a 30-day month
    ms = 59; mm = 59; mh = 23; mdow = 2; mday = 28; mmon = 2; myr = 24; mleap = 0;
    load_model(); tick_both();
    chk("R4 feb leap day", mday, 29);
    cmp_all("R4 feb29");
    ms = 59; mm = 59; mh = 23; mday = 28; mmon = 2; mleap = 1;
    load_model(); tick_both();
    cmp_all("R4 feb28");
    ms = 59; mm = 59; mh = 23; mday = 30; mmon = 4; mleap = 2;
    load_model(); tick_both();
    cmp_all("R4 apr30");

    // R5: 12-hour transitions
    m24 = 0; ms = 59; mm = 59; mh = 11; mpm = 0; mday = 10; mmon = 5;
    load_model(); tick_both();
    rd(4'h5, v); chk("R5 noon tens has PM", v, 3);
    rd(4'h4, v); chk("R5 noon units", v, 2);
    ms = 59; mm = 59; mh = 12; mpm = 1;
    load_model(); tick_both();
    cmp_all("R5 one pm");
    ms = 59; mm = 59; mh = 11; mpm = 1;
    load_model(); tick_both();
    rd(4'h5, v); chk("R5 midnight tens", v, 1);
    cmp_all("R5 midnight");

    // R5: back to 24-hour
    m24 = 1; mpm = 0; ms = 59; mm = 59; mh = 23; mday = 3; mmon = 3;
    load_model(); tick_both();
    cmp_all("R5 24h wrap");

    // R6: hold, then exactly one held second
    ms = 10; mm = 20; mh = 5;
    load_model();
    wr(4'hD, 4'h0);
    repeat (3) pulse();
    rd(4'h0, v); chk("R6 held", v, 0);
    wr(4'hD, 4'h8);
    m_tick();
    rd(4'h0, v); chk("R6 one second applied", v, 1);
    repeat (5) @(negedge clk);
    rd(4'h0, v); chk("R6 no second extra", v, 1);

    // R8: discard held second
    wr(4'hD, 4'h0);
    pulse();
    wr(4'hF, 4'h2);
    wr(4'hD, 4'h8);
    repeat (3) @(negedge clk);
    cmp_all("R8 discarded");

    // R9: alarm clear
    wr(4'hD, 4'h9);
    for (int i = 2; i <= 8; i++) wr(4'(i), 4'(i + 3));
    rd(4'h6, v); chk("R9 alarm stored", v, 9);
    wr(4'hF, 4'h1);
    for (int i = 2; i <= 8; i++) begin
      rd(4'(i), v); chk("R9 alarm cleared", v, 0);
    end
    // R12: unused setup addresses
    rd(4'h0, v); chk("R12 setup 0x0", v, 0);
    rd(4'h9, v); chk("R12 setup 0x9", v, 0);
    rd(4'hC, v); chk("R12 setup 0xC", v, 0);
    wr(4'hD, 4'h8);
    cmp_all("R9 time kept");

    // R10: scratch banks
    wr(4'hD, 4'hA);
    wr(4'h5, 4'h3); wr(4'hC, 4'h7); wr(4'h0, 4'hE);
    rd(4'hD, v); chk("R1 ctrl visible in scratch bank", v, 10);
    wr(4'hD, 4'hB);
    wr(4'h5, 4'hC); wr(4'hC, 4'h1);
    rd(4'h5, v); chk("R10 B word5", v, 12);
    rd(4'hC, v); chk("R10 B word12", v, 1);
    rd(4'h0, v); chk("R10 B word0 untouched", v, 0);
    wr(4'hD, 4'hA);
    rd(4'h5, v); chk("R10 A word5", v, 3);
    rd(4'hC, v); chk("R10 A word12", v, 7);
    rd(4'h0, v); chk("R10 A word0", v, 14);
    wr(4'hD, 4'h8);
    cmp_all("R10 time kept");

    // R11: test register
    wr(4'hE, 4'hF);
    rd(4'hE, v); chk("R11 test reads 0", v, 0);
    rd(4'hF, v); chk("R11 action reads 0", v, 0);
    s0 = ms;
    tick_both();
    rd(4'h0, v); chk("R11 counting unchanged", v, (s0 + 1) % 10);
    // R12: no strobe, no data
    @(negedge clk); bus_addr = 4'hD; bus_rd = 1'b0; #1;
    chk("R12 idle rdata", int'(bus_rdata), 0);

    // R3 R4 R5: random rounds, half near a month end
    for (int r = 0; r < 25; r++) begin
      m24 = $urandom % 2;
      mpm = 0;
      mh = m24 ? $urandom % 24 : 1 + $urandom % 12;
      if (!m24) mpm = $urandom % 2;
      mm = $urandom % 60; ms = $urandom % 60;
      mmon = 1 + $urandom % 12; mleap = $urandom % 4; myr = $urandom % 100;
      mdow = $urandom % 7;
      if ($urandom % 2) begin
        mm = 59; mh = m24 ? 23 : 11; mpm = m24 ? 0 : 1; mday = mdim(mmon, mleap);
      end else mday = 1 + $urandom % 28;
      load_model();
      n = $urandom % 900;
      for (int k = 0; k < n; k++) tick_both();
      cmp_all("R3 random");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule